// File: doc/BRIEF.md
# Fault Event Latch with Masking

This block collects up to fifteen one-bit fault indications, for example supply window detector outputs, general-purpose inputs and a watchdog flag. It brings them into the clock domain, watches them for any change of level, and keeps a frozen record that a host can read through a small register port. The first unmasked change on any source sets a summary "event" flag and freezes a snapshot of every source level at that moment. Later changes leave the record alone until the host reads the upper latched register. That read clears the record and re-arms capture.

Because an event is any edge and the record holds levels, a source that returns to its good state produces a record with the event flag set and that source's bit clear. Two mask registers, laid out like the latched registers, hide chosen sources. A masked source cannot raise the flag and always reads 0 in the latched registers. Two live status registers show the synchronized source levels without latching. The register width is a parameter `REG_W`, and the number of sources is `2*REG_W-1`.

Top module: `fault_event_latch`

## Requirements
- R1: A change of level in either direction on any unmasked synchronized source sets the event flag, which is bit 7 of the lower latched register at address 0.
- R2: While the event flag is set and no clearing read occurs, the flag and both latched registers hold their values, whatever the sources do.
- R3: The latched bits hold the source levels sampled when the flag set. Source i appears at bit i of address 0 for i < 7, and at bit i-7 of address 1 for i >= 7. A source that returns to 0 reads as 0 while the flag reads 1.
- R4: A read of address 1 (rd_en high) returns its contents and, at that clock edge, clears both latched registers and the flag, re-arming capture.
- R5: If a clearing read and an unmasked source change fall in the same cycle, the clear acts first and the new event is then latched, so the flag stays set with the new snapshot.
- R6: The mask registers at address 2 (sources 0..6 in bits 6:0) and address 3 (sources 7..14 in bits 7:0) use the latched bit map. A masked source never sets the flag and always reads 0 in the latched registers.
- R7: The event flag cannot be masked. Bit 7 of address 2 ignores writes and reads 0, and the flag still sets on an unmasked change.
- R8: Live status at address 4 (sources 0..6, bit 7 reserved and reading 0) and address 5 (sources 7..14) shows the synchronized levels and reads 0x00 after reset.
- R9: The mask registers are read/write and reset to 0x00. Writes to addresses 0, 1, 4 and 5 have no effect, and unused addresses read 0x00.
- R10: Reading address 0 has no side effects.
- R11: A source change becomes visible on the live status after two rising clock edges, and in the latched registers after three.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 2*REG_W-1 | Asynchronous fault source levels |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe; clears the record when addr is 1 |
| wr_en | input | 1 | Write strobe |
| wdata | input | REG_W | Write data |
| rdata | output | REG_W | Read data for addr, combinational |

## Verification
The hardest case to reach is a clearing read that lands in the same cycle as a fresh source edge. The edge exists inside the block for only one cycle, two edges after the source moves. The bench moves a source at a falling edge, counts two rising edges, and raises the clearing read for exactly the next one. It then expects the flag to be set again with the new snapshot. The bench also forces a source back into tolerance while the record is frozen. This shows that the record holds a level and not a fault kind.

// File: rtl/fel_pkg.sv
package fel_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_LAT_LO = 3'd0,
    A_LAT_HI = 3'd1,
    A_MSK_LO = 3'd2,
    A_MSK_HI = 3'd3,
    A_LIV_LO = 3'd4,
    A_LIV_HI = 3'd5
  } fel_addr_e;
endpackage

// File: rtl/fel_sync.sv
module fel_sync #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d_in;
      stg2_q <= stg1_q;
    end
  end

  assign d_out = stg2_q;
endmodule

// File: rtl/fel_capture.sv
module fel_capture #(
  parameter int N = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] mask,
  input  logic         clr,
  output logic         flag,
  output logic [N-1:0] snap
);
  logic [N-1:0] prev_q;
  logic [N-1:0] snap_q, snap_d;
  logic         flag_q, flag_d;
  logic [N-1:0] evt;
  logic         trig;
  logic         armed;
  logic         snap_en;

  always_comb begin
    evt     = (lvl ^ prev_q) & ~mask;
    trig    = |evt;
    armed   = ~flag_q | clr;
    flag_d  = flag_q;
    snap_d  = snap_q;
    snap_en = clr | (armed & trig);
    if (clr) begin
      flag_d = 1'b0;
      snap_d = '0;
    end
    if (armed && trig) begin
      flag_d = 1'b1;
      snap_d = lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= 1'b0;
      snap_q <= '0;
    end else begin
      prev_q <= lvl;
      flag_q <= flag_d;
      if (snap_en) snap_q <= snap_d;
    end
  end

  assign flag = flag_q;
  assign snap = snap_q;

  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> flag_q); // R1
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> (flag_q && $stable(snap_q))); // R2
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !trig) |=> (!flag_q && snap_q == '0)); // R4
  AST_CLEAR_RELATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && trig) |=> (flag_q && snap_q == $past(lvl))); // R5
endmodule

// File: rtl/fel_regs.sv
module fel_regs
  import fel_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int N     = 2*REG_W-1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  input  logic              flag,
  input  logic [N-1:0]      snap,
  input  logic [N-1:0]      lvl,
  output logic [REG_W-1:0]  rdata,
  output logic              clr,
  output logic [N-1:0]      mask
);
  localparam int LO_N = REG_W - 1;

  logic [LO_N-1:0]  mask_lo_q;
  logic [REG_W-1:0] mask_hi_q;
  logic             wen_lo, wen_hi;
  logic [N-1:0]     shown;

  always_comb begin
    wen_lo = wr_en && (addr == A_MSK_LO);
    wen_hi = wr_en && (addr == A_MSK_HI);
    clr    = rd_en && (addr == A_LAT_HI);
    mask   = {mask_hi_q, mask_lo_q};
    shown  = snap & ~mask;
    case (addr)
      A_LAT_LO: rdata = {flag, shown[LO_N-1:0]};
      A_LAT_HI: rdata = shown[N-1:LO_N];
      A_MSK_LO: rdata = {1'b0, mask_lo_q};
      A_MSK_HI: rdata = mask_hi_q;
      A_LIV_LO: rdata = {1'b0, lvl[LO_N-1:0]};
      A_LIV_HI: rdata = lvl[N-1:LO_N];
      default:  rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_lo_q <= '0;
      mask_hi_q <= '0;
    end else begin
      if (wen_lo) mask_lo_q <= wdata[LO_N-1:0];
      if (wen_hi) mask_hi_q <= wdata;
    end
  end

  AST_MASKED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_LAT_HI) |-> ((rdata & mask_hi_q) == '0)); // R6
  AST_MASK_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wen_hi |=> (mask_hi_q == $past(wdata))); // R9
endmodule

// File: rtl/fault_event_latch.sv
module fault_event_latch
  import fel_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*REG_W-2:0]   src_in,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wdata,
  output logic [REG_W-1:0]     rdata
);
  localparam int NUM_SRC = 2*REG_W - 1;

  logic [NUM_SRC-1:0] lvl;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] snap;
  logic               flag;
  logic               clr;

  fel_sync #(.W(NUM_SRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (src_in),
    .d_out (lvl)
  );

  fel_capture #(.N(NUM_SRC)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (lvl),
    .mask  (mask),
    .clr   (clr),
    .flag  (flag),
    .snap  (snap)
  );

  fel_regs #(.REG_W(REG_W), .N(NUM_SRC)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .wdata (wdata),
    .flag  (flag),
    .snap  (snap),
    .lvl   (lvl),
    .rdata (rdata),
    .clr   (clr),
    .mask  (mask)
  );

  AST_RSVD_LIVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_LIV_LO) |-> !rdata[REG_W-1]); // R8
endmodule

// File: tb/tb_fault_event_latch.sv
`timescale 1ns/1ps
module tb_fault_event_latch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] src_in;
  logic [2:0]  addr;
  logic        rd_en;
  logic        wr_en;
  logic [7:0]  wdata;
  logic [7:0]  rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // {clear-after(1), src(15), expected addr0(8), expected addr1(8)}
  localparam logic [31:0] VEC [8] = '{
    32'h0000_0000,
    32'h8008_8800,
    32'h0000_8000,
    32'h8400_8000,
    32'h8401_8108,
    32'hFFFF_FFFF,
    32'h8000_8000,
    32'h0000_0000
  };

  fault_event_latch #(.REG_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic c, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = c;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive_settle(input logic [14:0] s);
    @(negedge clk);
    src_in = s;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; src_in = '0; addr = '0; rd_en = 1'b0; wr_en = 1'b0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // Reset state R8 R9
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], 1'b0, d);
      check("R9 reset value", d, 8'h00);
    end
    rd(3'd4, 1'b0, d); check("R8 live reset", d, 8'h00);

    // Vector table: R1 R2 R3 R4
    for (int i = 0; i < 8; i++) begin
      drive_settle(VEC[i][30:16]);
      rd(3'd0, 1'b0, d); check("R1/R3 vector addr0", d, VEC[i][15:8]);
      rd(3'd1, VEC[i][31], d); check("R2/R3 vector addr1", d, VEC[i][7:0]);
      if (VEC[i][31]) begin
        rd(3'd0, 1'b0, d); check("R4 cleared", d, 8'h00);
      end
    end

    // R9 writes to read-only addresses ignored
    drive_settle(15'h0005);
    wr(3'd0, 8'h55); wr(3'd1, 8'hAA); wr(3'd4, 8'hFF);
    rd(3'd0, 1'b0, d); check("R9 write lat ignored", d, 8'h85);
    rd(3'd4, 1'b0, d); check("R9 write live ignored", d, 8'h05);
    rd(3'd1, 1'b1, d); check("R9 write lathi ignored", d, 8'h00);
    drive_settle(15'h0000);
    rd(3'd1, 1'b1, d);

    // R6 masking
    wr(3'd2, 8'h02);
    rd(3'd2, 1'b0, d); check("R6 mask readback", d, 8'h02);
    drive_settle(15'h0002);
    rd(3'd0, 1'b0, d); check("R6 masked edge no flag", d, 8'h00);
    drive_settle(15'h0006);
    rd(3'd0, 1'b0, d); check("R6 masked bit reads 0", d, 8'h84);
    rd(3'd1, 1'b1, d);
    wr(3'd3, 8'h01);
    drive_settle(15'h0086);
    rd(3'd0, 1'b0, d); check("R6 upper mask no flag", d, 8'h00);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    drive_settle(15'h0000);
    rd(3'd1, 1'b1, d);

    // R7 flag not maskable
    wr(3'd2, 8'hFF);
    rd(3'd2, 1'b0, d); check("R7 mask bit7 reads 0", d, 8'h7F);
    drive_settle(15'h0100);
    rd(3'd0, 1'b0, d); check("R7 flag still sets", d, 8'h80);
    rd(3'd1, 1'b1, d); check("R7 upper snapshot", d, 8'h02);
    wr(3'd2, 8'h00);
    drive_settle(15'h0000);
    rd(3'd1, 1'b1, d);

    // R8 live status
    drive_settle(15'h7FFF);
    rd(3'd4, 1'b0, d); check("R8 live lo reserved", d, 8'h7F);
    rd(3'd5, 1'b0, d); check("R8 live hi", d, 8'hFF);
    drive_settle(15'h0000);
    rd(3'd1, 1'b1, d);
    drive_settle(15'h0000);
    rd(3'd1, 1'b1, d);

    // R11 latency
    @(negedge clk); src_in = 15'h0001; addr = 3'd0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R11 not latched after 2 edges", rdata, 8'h00);
    addr = 3'd4; #1 check("R11 live after 2 edges", rdata, 8'h01);
    addr = 3'd0;
    @(posedge clk); @(negedge clk);
    check("R11 latched after 3 edges", rdata, 8'h81);

    // R10 address 0 read has no side effect
    rd(3'd0, 1'b1, d); check("R10 first read", d, 8'h81);
    rd(3'd0, 1'b1, d); check("R10 second read", d, 8'h81);

    // R5 clear and edge in same cycle
    @(negedge clk); src_in = 15'h0003;
    @(posedge clk); @(posedge clk); @(negedge clk);
    addr = 3'd1; rd_en = 1'b1;
    #1 check("R5 read before clear", rdata, 8'h00);
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; addr = 3'd0;
    #1 check("R5 relatched after clear", rdata, 8'h83);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule